// File: doc/BRIEF.md
# Gated Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames. A byte is first placed in a one-entry holding buffer. When the shift stage is free, the byte moves into the shift stage and goes out bit by bit. The shift stage is paced by an external transmit clock: the line changes only when that clock falls. Each frame has a low start bit, then the data least significant bit first, an optional parity bit, and one or two high stop bits. When the shift stage finishes a frame and the buffer already holds the next byte, the next frame starts at once.

A transmit-enable input decides whether new bytes are accepted. Clearing it does not cut off a byte that was already written: that byte still goes out in full. A byte written while the enable is low is discarded, so it never reaches the line. A send-break input holds the line low for as long as it is asserted. Two flags report the transmitter state. Ready means the buffer can take a byte. Empty means nothing is buffered and nothing is being shifted.

The external transmit clock is sampled in the system clock domain and must be synchronous to it. A falling edge is seen when the sampled value was high on one system clock edge and the input is low at the next.

Top module: `sertx_core`

## Requirements
- R1: While reset is asserted and right after it is released, the serial line is high, ready is high and empty is high.
- R2: With send-break steady, the serial line changes only on the system clock edge at which a falling transmit-clock edge is detected.
- R3: A frame is sent in this order:
  - a low start bit;
  - DATA_W data bits, least significant first;
  - when parity is enabled, a parity bit, which is the XOR of the data bits for even parity and its inverse for odd parity;
  - one high stop bit, or two when two-stop is set.

  Each bit lasts one transmit-clock period. The format inputs are taken at the edge where the frame starts.
- R4: A write accepted with ready high clears ready on the next cycle. Ready sets again on the transmit-clock fall at which the byte moves into the shift stage.
- R5: A write while ready is low is ignored. The buffered byte is the one that is sent.
- R6: When a byte is buffered as the last stop bit ends, its start bit follows with no idle bit in between.
- R7: Empty is high exactly when the buffer holds no byte and no frame is in progress.
- R8: A byte written while enabled is transmitted completely even if the enable drops before or during its frame.
- R9: A write while the enable is low is discarded. Nothing is sent, and ready and empty stay high.
- R10: While send-break is high the serial line is low. When send-break is released, the line shows the frame state again.
- R11: With no frame in progress and no break, the serial line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txc | input | 1 | External transmit clock; bits advance on its falling edge |
| tx_en | input | 1 | Transmit enable; gates acceptance of new bytes |
| send_break | input | 1 | Holds the serial line low while high |
| par_en | input | 1 | Adds a parity bit to each frame |
| par_odd | input | 1 | Selects odd parity (1) or even parity (0) |
| two_stop | input | 1 | Selects two stop bits (1) or one (0) |
| wr_stb | input | 1 | One-cycle write strobe for wr_data |
| wr_data | input | DATA_W | Byte to transmit |
| serial_out | output | 1 | Serial line |
| tx_ready | output | 1 | Holding buffer can accept a byte |
| tx_empty | output | 1 | No byte buffered and no frame in progress |

## Verification
The line is driven with several kinds of traffic, each aimed at a different fault:
- Single isolated bytes with all four format combinations. These separate errors in bit order, parity polarity and stop-bit count.
- Bytes written back-to-back while a frame is in progress. This shows whether the buffer-to-shifter hand-off loses a bit period or drops a byte.
- Writes arriving while ready is low. These reveal a buffer that gets overwritten.
- Dropping the enable with a byte pending, and then writing while disabled. This separates the "finish what was written" rule from the "discard new writes" rule.
- A break pulse asserted in the middle of a frame. This confirms that forcing the line low does not disturb the frame that continues underneath.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } sertx_fmt_t;
endpackage

// File: rtl/sertx_holding.sv
module sertx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic              full_d;
  logic [DATA_W-1:0] data_d;
  logic              accept;

  assign accept = wr_stb & tx_en & ~full;

  always_comb begin
    full_d = full;
    data_d = data;
    if (take) full_d = 1'b0;
    if (accept) begin
      full_d = 1'b1;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      if (accept) data <= data_d;
    end
  end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FW = DATA_W + 4,
  localparam int CW = $clog2(FW + 1)
) (
  input  sertx_fmt_t        fmt,
  input  logic [DATA_W-1:0] data,
  output logic [FW-1:0]     frame,
  output logic [CW-1:0]     flen
);
  logic par_bit;

  assign par_bit = (^data) ^ fmt.par_odd;

  always_comb begin
    frame = '1;
    frame[0] = 1'b0;
    frame[DATA_W:1] = data;
    if (fmt.par_en) frame[DATA_W+1] = par_bit;
    flen = CW'(DATA_W + 2) + CW'(fmt.par_en) + CW'(fmt.two_stop);
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int DATA_W = 8,
  localparam int FW = DATA_W + 4,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic          hold_full,
  input  logic [FW-1:0] frame_in,
  input  logic [CW-1:0] flen_in,
  output logic          take,
  output logic          busy,
  output logic          bit_out
);
  logic [FW-1:0] frm_q, frm_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign busy    = (cnt_q != '0);
  assign last    = (cnt_q == CW'(1));
  assign take    = fall & hold_full & (~busy | last);
  assign bit_out = frm_q[0];

  always_comb begin
    frm_d = frm_q;
    cnt_d = cnt_q;
    if (take) begin
      frm_d = frame_in;
      cnt_d = flen_in;
    end else if (fall && busy) begin
      frm_d = {1'b1, frm_q[FW-1:1]};
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= '1;
      cnt_q <= '0;
    end else if (fall) begin
      frm_q <= frm_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txc,
  input  logic              tx_en,
  input  logic              send_break,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              serial_out,
  output logic              tx_ready,
  output logic              tx_empty
);
  localparam int FW = DATA_W + 4;
  localparam int CW = $clog2(FW + 1);

  logic              txc_q;
  logic              fall;
  logic              take;
  logic              busy;
  logic              bit_out;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic [FW-1:0]     frame;
  logic [CW-1:0]     flen;
  sertx_fmt_t        fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txc_q <= 1'b0;
    else        txc_q <= txc;
  end

  assign fall = txc_q & ~txc;
  assign fmt  = '{par_en: par_en, par_odd: par_odd, two_stop: two_stop};

  sertx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .tx_en(tx_en),
    .wr_data(wr_data), .take(take), .full(hold_full), .data(hold_data)
  );

  sertx_framer #(.DATA_W(DATA_W)) u_frame (
    .fmt(fmt), .data(hold_data), .frame(frame), .flen(flen)
  );

  sertx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .fall(fall), .hold_full(hold_full),
    .frame_in(frame), .flen_in(flen), .take(take), .busy(busy),
    .bit_out(bit_out)
  );

  assign serial_out = ~send_break & (busy ? bit_out : 1'b1);
  assign tx_ready   = ~hold_full;
  assign tx_empty   = ~hold_full & ~busy;
endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
  input logic clk,
  input logic rst_n,
  input logic txc,
  input logic tx_en,
  input logic send_break,
  input logic wr_stb,
  input logic serial_out,
  input logic tx_ready,
  input logic tx_empty
);
  logic txc_seen;
  logic fall_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txc_seen <= 1'b0;
    else        txc_seen <= txc;
  end
  assign fall_now = txc_seen & ~txc;

  assert_line_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_now |=> ($stable(serial_out) || !$stable(send_break)));

  assert_ready_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && tx_en && tx_ready) |=> !tx_ready);

  assert_empty_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_ready);

  assert_drop_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !tx_en && tx_ready) |=> tx_ready);

  assert_break_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    send_break |-> !serial_out);

  assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !send_break) |-> serial_out);
endmodule

bind sertx_core sertx_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txc(txc), .tx_en(tx_en),
  .send_break(send_break), .wr_stb(wr_stb), .serial_out(serial_out),
  .tx_ready(tx_ready), .tx_empty(tx_empty)
);

// File: tb/sertx_core_test.sv
`timescale 1ns/1ps
module sertx_core_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txc = 1'b1;
  logic tx_en = 1'b0;
  logic send_break = 1'b0;
  logic par_en = 1'b0;
  logic par_odd = 1'b0;
  logic two_stop = 1'b0;
  logic wr_stb = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic serial_out, tx_ready, tx_empty;

  int checks = 0;
  int errors = 0;
  bit txc_run = 1'b0;
  bit finished = 1'b0;

  // reference model state
  bit m_full = 1'b0;
  bit [DW-1:0] m_data = '0;
  bit m_txcp = 1'b0;
  bit q[$];

  always #2 clk = ~clk;

  sertx_core #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .txc(txc), .tx_en(tx_en),
    .send_break(send_break), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .wr_stb(wr_stb), .wr_data(wr_data),
    .serial_out(serial_out), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_full = 1'b0; m_txcp = 1'b0; q.delete();
    end else begin
      bit was_full;
      was_full = m_full;
      if (m_txcp && !txc) begin
        if (q.size() > 0) void'(q.pop_front());
        if (q.size() == 0 && was_full) begin
          q.push_back(1'b0);
          for (int i = 0; i < DW; i++) q.push_back(m_data[i]);
          if (par_en) q.push_back((^m_data) ^ par_odd);
          q.push_back(1'b1);
          if (two_stop) q.push_back(1'b1);
          m_full = 1'b0;
        end
      end
      if (wr_stb && tx_en && !was_full) begin
        m_full = 1'b1; m_data = wr_data;
      end
      m_txcp = txc;
    end
  end

  // compare with the model on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R3 R6 R8 R10 R11 line", serial_out,
            send_break ? 1'b0 : (q.size() > 0 ? q[0] : 1'b1));
      check("R4 R5 R9 ready", tx_ready, !m_full);
      check("R7 empty", tx_empty, (q.size() == 0) && !m_full);
    end
  end

  // transmit clock: period of four system clocks
  initial begin
    forever begin
      @(negedge clk);
      if (txc_run) begin
        @(negedge clk); txc = ~txc;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(input logic [DW-1:0] d);
    wr_stb = 1'b1; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic put_when_ready(input logic [DW-1:0] d);
    while (!tx_ready) @(negedge clk);
    put(d);
  endtask

  task automatic drain();
    while (!tx_empty) @(negedge clk);
    idle(8);
  endtask

  initial begin
    int lows;
    idle(3);
    check("R1 line in reset", serial_out, 1'b1);
    check("R1 ready in reset", tx_ready, 1'b1);
    check("R1 empty in reset", tx_empty, 1'b1);
    rst_n = 1'b1;
    idle(1);
    check("R1 line after reset", serial_out, 1'b1);
    check("R1 ready after reset", tx_ready, 1'b1);
    check("R1 empty after reset", tx_empty, 1'b1);
    txc_run = 1'b1;
    tx_en = 1'b1;
    idle(10);

    // R3 single frames, all formats
    for (int f = 0; f < 4; f++) begin
      par_en = f[0]; par_odd = f[1]; two_stop = f[1] ^ f[0];
      put_when_ready(8'hA5 ^ 8'(f * 8'h31));
      drain();
    end

    // R4 ready clears right after the write
    par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b0;
    put(8'h3C);
    check("R4 ready low after write", tx_ready, 1'b0);
    // R5 write while ready low is dropped
    put(8'hFF);
    // R6 back-to-back bytes
    put_when_ready(8'h81);
    put_when_ready(8'h7E);
    put_when_ready(8'h00);
    drain();

    // R8 disable with a byte waiting in the buffer and one shifting
    put_when_ready(8'h55);
    put_when_ready(8'hC3);
    tx_en = 1'b0;
    drain();
    check("R8 empty after pending bytes", tx_empty, 1'b1);

    // R9 writes while disabled are never sent
    lows = 0;
    put(8'h00);
    check("R9 ready after disabled write", tx_ready, 1'b1);
    check("R9 empty after disabled write", tx_empty, 1'b1);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (!serial_out) lows++;
    end
    check("R9 line never low", lows == 0, 1'b1);

    // R10 break in the middle of a frame, then idle break
    tx_en = 1'b1;
    put_when_ready(8'h96);
    idle(14);
    send_break = 1'b1;
    idle(9);
    check("R10 line low during break", serial_out, 1'b0);
    send_break = 1'b0;
    drain();
    send_break = 1'b1;
    idle(12);
    check("R10 idle break low", serial_out, 1'b0);
    send_break = 1'b0;
    idle(2);
    check("R11 idle line high", serial_out, 1'b1);

    // R2 line stays put while transmit clock is frozen
    put_when_ready(8'h0F);
    idle(12);
    txc_run = 1'b0;
    idle(2);
    begin
      logic held;
      held = serial_out;
      idle(20);
      check("R2 line held without txc fall", serial_out, held);
    end
    txc_run = 1'b1;
    drain();

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule